// File: doc/BRIEF.md
# Vector Command Stream Unpacker

This block sits between a DMA engine and a vector coprocessor. The DMA engine pushes 128-bit entries into a 16-entry input queue. The block reads each entry as four 32-bit words, lowest word first, and interprets them as a stream of command words followed by their payload. Two payload-carrying commands write into two separate memories of the coprocessor. The program-load command copies 64-bit instruction words into code memory. The unpack command packs groups of four 32-bit words into 128-bit words and writes them into data memory.

Data memory writes follow a strided pattern that a cycle register sets. A run of CL consecutive words is written, and then the destination skips forward by WL−CL words before the next run. The input side uses valid/ready. An entry is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low while the queue holds 16 entries, and the producer must then hold its entry stable until `in_ready` returns. The block drains one 32-bit word per cycle whenever the queue is not empty. The memory write ports are plain strobes that the memories always accept.

Top module: `vcu_unpacker`

## Requirements
- R1: A command word holds the opcode in bits 31:24, the count in bits 23:16 and the immediate in bits 15:0. Opcode 0x00 and every opcode not listed below consume only their command word and cause no write.
- R2: Accepted entries are consumed in order, each from its low 32-bit word to its high one. While 16 entries are held, `in_ready` is low, and no entry is lost.
- R3: Opcode 0x4A loads count 64-bit instructions. Each instruction is taken from two words, the first word forming bits 31:0. They are written to code memory starting at the immediate (in 64-bit units), with the address stepping by one for each instruction.
- R4: Opcode 0x6C reads four words per data write, forming {w3,w2,w1,w0} with w0 the first word read. It writes count 128-bit words, starting at the low bits of the immediate (in 128-bit units).
- R5: A count of 0 means 256 for both 0x4A and 0x6C.
- R6: Opcode 0x01 loads CL from immediate bits 7:0 and WL from immediate bits 15:8. The values persist until the next 0x01 or reset.
- R7: When CL is nonzero and WL is greater than CL, an unpack writes CL consecutive words and then advances the address by an extra WL−CL before the next write. The run position restarts at each unpack command.
- R8: When CL is 0 or WL is not greater than CL, unpack addresses step by one.
- R9: Opcode 0x30 consumes four trailing data words and writes nothing. The word after them is decoded as a command.
- R10: Code and data addresses wrap modulo their memory sizes, and the two address spaces are independent.
- R11: After reset there is no write strobe, `in_ready` is high, and CL=WL=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer has an entry |
| in_ready | output | 1 | Queue can accept an entry |
| in_data | input | 128 | Entry of four 32-bit words, word 0 in bits 31:0 |
| code_we | output | 1 | Code memory write strobe |
| code_addr | output | CODE_AW | Code memory address, 64-bit units |
| code_wdata | output | 64 | Instruction word |
| data_we | output | 1 | Data memory write strobe |
| data_addr | output | DATA_AW | Data memory address, 128-bit units |
| data_wdata | output | 128 | Packed data word |

## Verification
The bench builds the block with its default sizes: a 16-entry queue, an 11-bit code address and a 10-bit data address. Pushing entries back to back, four times faster than the block drains them, fills the 16-entry queue within about twenty entries, so back-pressure is exercised. An unpack of 256 words starting near the top of the 10-bit data space, and a program load starting at the last code address, both cross the wrap point. Random command mixes then combine stride settings, discarded payloads and all opcodes with random gaps in `in_valid`.

// File: rtl/vcu_pkg.sv
package vcu_pkg;
  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_SETCYC = 8'h01;
  localparam logic [7:0] OP_DROP4  = 8'h30;
  localparam logic [7:0] OP_PROG   = 8'h4A;
  localparam logic [7:0] OP_UNPK   = 8'h6C;

  typedef enum logic [2:0] {
    ST_CMD, ST_PLO, ST_PHI, ST_UNP, ST_DROP
  } seq_state_t;
endpackage

// File: rtl/vcu_fifo.sv
module vcu_fifo #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  output logic             head_valid,
  output logic [WIDTH-1:0] head_data,
  input  logic             pop
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [PW:0]      cnt;
  logic             do_push, do_pop;

  assign push_ready = (cnt < (PW+1)'(DEPTH));
  assign head_valid = (cnt != '0);
  assign head_data  = mem[rp];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end
  end

  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));
  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> head_valid);
endmodule

// File: rtl/vcu_skipgen.sv
module vcu_skipgen #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  input  logic [7:0]    cl,
  input  logic [7:0]    wl,
  output logic [AW-1:0] addr
);
  logic [7:0]    run;
  logic          linear;
  logic [8:0]    gap;
  logic [AW+9:0] nxt;

  assign linear = (cl == 8'd0) || (wl <= cl);
  assign gap    = (!linear && (run + 8'd1 == cl)) ? {1'b0, wl - cl} : 9'd0;
  assign nxt    = {10'd0, addr} + (AW+10)'(1) + (AW+10)'(gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      run  <= '0;
    end else if (start) begin
      addr <= start_addr;
      run  <= '0;
    end else if (step) begin
      addr <= nxt[AW-1:0];
      run  <= (gap != 9'd0) ? 8'd0 : run + 8'd1;
    end
  end

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && cl == 8'd0) |=> addr == $past(addr) + AW'(1));
  // R7
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr == $past(start_addr)));
endmodule

// File: rtl/vcu_seq.sv
module vcu_seq
  import vcu_pkg::*;
#(
  parameter int CODE_AW = 11,
  parameter int DATA_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wv,
  input  logic [31:0]        w,
  output logic               gen_start,
  output logic [DATA_AW-1:0] gen_start_addr,
  output logic               gen_step,
  input  logic [DATA_AW-1:0] gen_addr,
  output logic [7:0]         cl,
  output logic [7:0]         wl,
  output logic               code_we,
  output logic [CODE_AW-1:0] code_addr,
  output logic [63:0]        code_wdata,
  output logic               data_we,
  output logic [DATA_AW-1:0] data_addr,
  output logic [127:0]       data_wdata
);
  seq_state_t   st;
  logic [8:0]   rem;
  logic [1:0]   sub;
  logic [31:0]  hold [3];
  logic [31:0]  lo;
  logic [CODE_AW-1:0] caddr;
  logic [7:0]   op, num;
  logic [15:0]  imm;
  logic [8:0]   n_full;

  assign op     = w[31:24];
  assign num    = w[23:16];
  assign imm    = w[15:0];
  assign n_full = (num == 8'd0) ? 9'd256 : {1'b0, num};

  assign gen_start      = wv && (st == ST_CMD) && (op == OP_UNPK);
  assign gen_start_addr = imm[DATA_AW-1:0];
  assign gen_step       = wv && (st == ST_UNP) && (sub == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD; rem <= '0; sub <= '0; lo <= '0; caddr <= '0;
      cl <= '0; wl <= '0;
      hold[0] <= '0; hold[1] <= '0; hold[2] <= '0;
      code_we <= 1'b0; code_addr <= '0; code_wdata <= '0;
      data_we <= 1'b0; data_addr <= '0; data_wdata <= '0;
    end else begin
      code_we <= 1'b0;
      data_we <= 1'b0;
      if (wv) begin
        unique case (st)
          ST_CMD: begin
            sub <= '0;
            rem <= n_full;
            case (op)
              OP_SETCYC: begin cl <= imm[7:0]; wl <= imm[15:8]; end
              OP_PROG:   begin caddr <= imm[CODE_AW-1:0]; st <= ST_PLO; end
              OP_UNPK:   st <= ST_UNP;
              OP_DROP4:  st <= ST_DROP;
              default:   st <= ST_CMD;
            endcase
          end
          ST_PLO: begin lo <= w; st <= ST_PHI; end
          ST_PHI: begin
            code_we    <= 1'b1;
            code_addr  <= caddr;
            code_wdata <= {w, lo};
            caddr      <= caddr + 1'b1;
            rem        <= rem - 1'b1;
            st         <= (rem == 9'd1) ? ST_CMD : ST_PLO;
          end
          ST_UNP: begin
            sub <= sub + 1'b1;
            if (sub != 2'd3) hold[sub] <= w;
            else begin
              data_we    <= 1'b1;
              data_addr  <= gen_addr;
              data_wdata <= {w, hold[2], hold[1], hold[0]};
              rem        <= rem - 1'b1;
              if (rem == 9'd1) st <= ST_CMD;
            end
          end
          ST_DROP: begin
            sub <= sub + 1'b1;
            if (sub == 2'd3) st <= ST_CMD;
          end
          default: st <= ST_CMD;
        endcase
      end
    end
  end

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_we && data_we));
  // R4
  four_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> !data_we);
  // R3
  two_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_we |=> !code_we);
endmodule

// File: rtl/vcu_unpacker.sv
module vcu_unpacker #(
  parameter int DEPTH   = 16,
  parameter int CODE_AW = 11,
  parameter int DATA_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [127:0]       in_data,
  output logic               code_we,
  output logic [CODE_AW-1:0] code_addr,
  output logic [63:0]        code_wdata,
  output logic               data_we,
  output logic [DATA_AW-1:0] data_addr,
  output logic [127:0]       data_wdata
);
  localparam int LANES = 4;

  logic         head_valid;
  logic [127:0] head_data;
  logic [1:0]   lane;
  logic [31:0]  lane_word [LANES];
  logic         gen_start, gen_step;
  logic [DATA_AW-1:0] gen_start_addr, gen_addr;
  logic [7:0]   cl, wl;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_word[g] = head_data[32*g +: 32];
  end

  vcu_fifo #(.WIDTH(128), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_ready(in_ready), .push_data(in_data),
    .head_valid(head_valid), .head_data(head_data),
    .pop(head_valid && lane == 2'd3)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane <= '0;
    else if (head_valid) lane <= lane + 1'b1;
  end

  vcu_seq #(.CODE_AW(CODE_AW), .DATA_AW(DATA_AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wv(head_valid), .w(lane_word[lane]),
    .gen_start(gen_start), .gen_start_addr(gen_start_addr),
    .gen_step(gen_step), .gen_addr(gen_addr),
    .cl(cl), .wl(wl),
    .code_we(code_we), .code_addr(code_addr), .code_wdata(code_wdata),
    .data_we(data_we), .data_addr(data_addr), .data_wdata(data_wdata)
  );

  vcu_skipgen #(.AW(DATA_AW)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .start(gen_start), .start_addr(gen_start_addr), .step(gen_step),
    .cl(cl), .wl(wl), .addr(gen_addr)
  );

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |-> head_valid);
endmodule

// File: tb/test_vcu_unpacker.sv
module test_vcu_unpacker;
  localparam int CAW = 11;
  localparam int DAW = 10;
  localparam int MAXW = 8192;
  localparam int MAXE = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_data = '0;
  logic code_we, data_we;
  logic [CAW-1:0] code_addr;
  logic [63:0] code_wdata;
  logic [DAW-1:0] data_addr;
  logic [127:0] data_wdata;

  always #10 clk = ~clk;

  vcu_unpacker #(.DEPTH(16), .CODE_AW(CAW), .DATA_AW(DAW)) i_vcu_unpacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .code_we(code_we), .code_addr(code_addr),
    .code_wdata(code_wdata), .data_we(data_we), .data_addr(data_addr),
    .data_wdata(data_wdata)
  );

  logic [31:0]  words [MAXW];
  int           nw = 0;
  bit           e_code [MAXE];
  int           e_addr [MAXE];
  logic [127:0] e_data [MAXE];
  string        e_tag  [MAXE];
  int           ne = 0;
  int           widx = 0;
  int           n_chk = 0, n_bad = 0;
  int           cyc = 0;
  bit           saw_full = 0;
  bit           gap_mode = 0;

  task automatic check(bit ok, string tag, string what, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [31:0] w);
    words[nw] = w;
    nw++;
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] num, logic [15:0] imm);
    int pay;
    put({op, num, imm});
    pay = 0;
    if (op == 8'h4A) pay = 2 * ((num == 0) ? 256 : num);
    if (op == 8'h6C) pay = 4 * ((num == 0) ? 256 : num);
    if (op == 8'h30) pay = 4;
    for (int k = 0; k < pay; k++) put($urandom);
  endtask

  task automatic expect_wr(bit is_code, int a, logic [127:0] d, string t);
    e_code[ne] = is_code; e_addr[ne] = a; e_data[ne] = d; e_tag[ne] = t;
    ne++;
  endtask

  // Expected writes from the requirement text
  task automatic build_expect();
    int i, cl, wl, n, a, run, a0;
    string pend, t;
    logic [31:0] w;
    bit lin;
    i = 0; cl = 0; wl = 0; pend = "";
    while (i < nw) begin
      w = words[i]; i++;
      n = (w[23:16] == 0) ? 256 : int'(w[23:16]);
      case (w[31:24])
        8'h01: begin cl = w[7:0]; wl = w[15:8]; pend = ""; end
        8'h30: begin i += 4; pend = "R9"; end
        8'h4A: begin
          a0 = w[CAW-1:0];
          t = (pend != "") ? pend : ((a0 + n > (1 << CAW)) ? "R3 R10" : "R3");
          for (int k = 0; k < n; k++) begin
            a = (a0 + k) % (1 << CAW);
            expect_wr(1, a, {64'd0, words[i+1], words[i]}, t);
            i += 2;
          end
          pend = "";
        end
        8'h6C: begin
          a = w[DAW-1:0]; run = 0;
          lin = (cl == 0) || (wl <= cl);
          if (pend != "") t = pend;
          else if (w[23:16] == 0) t = "R5 R10";
          else if (!lin) t = "R6 R7";
          else if (cl != 0) t = "R8";
          else t = "R4";
          for (int k = 0; k < n; k++) begin
            expect_wr(0, a, {words[i+3], words[i+2], words[i+1], words[i]}, t);
            i += 4;
            if (!lin && run + 1 == cl) begin a = a + 1 + wl - cl; run = 0; end
            else begin a = a + 1; run++; end
            a = a % (1 << DAW);
          end
          pend = "";
        end
        default: pend = "R1";
      endcase
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && (code_we || data_we)) begin
      if (widx >= ne) check(0, "R2", "extra write", {code_we, data_we}, 0);
      else if (e_code[widx]) begin
        check(code_we && !data_we, e_tag[widx], "code port", {code_we, data_we}, 2'b10);
        check(code_addr == e_addr[widx][CAW-1:0], e_tag[widx], "code addr",
              code_addr, e_addr[widx]);
        check(code_wdata == e_data[widx][63:0], e_tag[widx], "code data",
              code_wdata, e_data[widx][63:0]);
      end else begin
        check(data_we && !code_we, e_tag[widx], "data port", {code_we, data_we}, 2'b01);
        check(data_addr == e_addr[widx][DAW-1:0], e_tag[widx], "data addr",
              data_addr, e_addr[widx]);
        check(data_wdata == e_data[widx], e_tag[widx], "data word",
              data_wdata, e_data[widx]);
      end
      widx++;
    end
  end

  task automatic push_all();
    int ne_ent;
    ne_ent = (nw + 3) / 4;
    for (int e = 0; e < ne_ent; e++) begin
      while (gap_mode && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = {words[4*e+3], words[4*e+2], words[4*e+1], words[4*e]};
      while (!in_ready && cyc < 150000) begin
        saw_full = 1;
        @(negedge clk);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic run_batch();
    while (nw % 4 != 0) put(32'h0);
    build_expect();
    push_all();
    while (widx < ne && cyc < 150000) @(negedge clk);
    repeat (20) @(negedge clk);
    nw = 0;
  endtask

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);
    check(code_we == 1'b0 && data_we == 1'b0, "R11", "strobes in reset",
          {code_we, data_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed batch
    cmd(8'h00, 8'h00, 16'h0000);          // R1
    cmd(8'h4A, 8'd2, 16'd5);
    cmd(8'h6C, 8'd3, 16'd0);              // R4 linear with CL=WL=0 (R11)
    cmd(8'h01, 8'h00, {8'd5, 8'd2});      // R6 CL=2 WL=5
    cmd(8'h6C, 8'd6, 16'd10);             // R7
    cmd(8'h6C, 8'd3, 16'd100);            // R7 run restarts
    cmd(8'h01, 8'h00, {8'd2, 8'd3});      // R8 WL<CL
    cmd(8'h6C, 8'd4, 16'd40);
    cmd(8'h30, 8'h00, 16'h0000);          // R9
    cmd(8'h6C, 8'd2, 16'd60);
    cmd(8'hEE, 8'h05, 16'h1234);          // R1 unknown opcode
    cmd(8'h4A, 8'd2, 16'd2047);           // R10 code wrap
    cmd(8'h01, 8'h00, 16'h0000);
    cmd(8'h6C, 8'd0, 16'd1000);           // R5 and R10 data wrap
    cmd(8'h4A, 8'd0, 16'd0);              // R5 code count 256
    run_batch();
    // R2 back-to-back pushing must have filled the queue
    check(saw_full, "R2", "in_ready low when full", saw_full, 1);

    // random batch
    gap_mode = 1;
    for (int r = 0; r < 40; r++) begin
      case ($urandom % 5)
        0: cmd(8'h00, 8'($urandom), 16'($urandom));
        1: cmd(8'h01, 8'h00, {8'($urandom % 7), 8'($urandom % 5)});
        2: cmd(8'h4A, 8'(1 + $urandom % 6), 16'($urandom));
        3: cmd(8'h6C, 8'(1 + $urandom % 8), 16'($urandom));
        default: cmd(8'h30, 8'h00, 16'h0000);
      endcase
    end
    run_batch();

    check(widx == ne, "R2", "write count", widx, ne);
    if (cyc >= 150000) check(0, "R2", "watchdog expired", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule